// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block drives the pins of a one-time-programmable fuse macro through a complete read. Software sets it up through a small write port. It writes two 32-bit unlock words, a starting bit address, and a control word that holds the byte count and the blank-check mode flag. Writing the control word is the start request. Once a request is accepted, the block enables the macro, pulses its reset, waits out the recovery time, and raises read enable. For each byte it holds the address for a settle interval, then captures the low byte of the macro output into an 8-entry FIFO. Software drains the FIFO through a pop/data pair.

Every interval is a whole number of clock cycles. It is worked out from a picosecond duration parameter and the clock period parameter, rounded up, so the same block can run at a different clock by changing parameters only. A successful read clears both unlock words, so every read needs a fresh unlock.

Top module: `fuse_read_seq`

## Requirements
- R1: A start request is accepted only while unlock word 0 (select 0) holds 0xEBCF0000 and unlock word 1 (select 1) holds 0xEBCF1111. Any other value sets `err_key`, and the macro pins do not move.
- R2: The byte count is in control bits [3:0] (select 3). A count of 0, or a count above the FIFO depth, sets `err_count`, and the macro pins do not move.
- R3: A start request made while `busy` is high is ignored and sets `err_busy`. All three error flags are sticky, and the next accepted request clears them.
- R4: After acceptance, `fuse_ceb_n` goes low for exactly one cycle with `fuse_rstb_n` still high. Then `fuse_rstb_n` is low for ceil(20 ns / Tclk) cycles. Then it is high for ceil(1 us / Tclk) cycles before read enable rises.
- R5: Read enable and each byte address are held for ceil(70 ns / Tclk) cycles before that byte is captured. When control bit 4 is set (blank-check mode), the hold is ceil(1.5 us / Tclk) cycles.
- R6: The first byte is read at the bit address in select 2. Each further byte is read at the previous address plus 8. The address outputs are 0 while read enable is low.
- R7: Only bits [7:0] of the macro output are stored. The bytes are stored in the order they were read.
- R8: After the last capture, read enable is low for one cycle with `fuse_ceb_n` still low. Then `fuse_ceb_n` goes high. `done` pulses for one cycle in that same cycle. `busy` is high from the cycle after acceptance until `fuse_ceb_n` is high again.
- R9: Both unlock words are cleared when a read completes.
- R10: The FIFO holds 8 bytes. `rd_valid` means it is not empty, and `rd_pop` removes the head. A capture that arrives while the FIFO is full is stored only if a pop happens in the same cycle. Otherwise that byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 unlock 0, 1 unlock 1, 2 start address, 3 control/start |
| cfg_wdata | input | 32 | Write data |
| rd_pop | input | 1 | Remove the FIFO head |
| rd_data | output | 8 | FIFO head byte |
| rd_valid | output | 1 | FIFO not empty |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| err_key | output | 1 | Sticky: request refused, bad unlock |
| err_count | output | 1 | Sticky: request refused, bad count |
| err_busy | output | 1 | Sticky: request made while busy |
| fuse_ceb_n | output | 1 | Macro chip enable, active low |
| fuse_rstb_n | output | 1 | Macro reset, active low |
| fuse_rden | output | 1 | Macro read enable |
| fuse_addr | output | 16 | Macro bit address |
| fuse_dout | input | 32 | Macro data output |

## Verification
A byte capture and a software pop can land in the same cycle. The case that matters is when the FIFO is already full from an earlier read that was not drained. The bench provokes this by starting a one-byte read while the FIFO is full and raising `rd_pop` in exactly the final settle cycle. It then drains the FIFO and expects the seven older bytes followed by the new byte. The same read without the pop must leave the eight older bytes untouched.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

    localparam int CNT_W = 4;

    localparam logic [31:0] UNLOCK_WORD0 = 32'hEBCF_0000;
    localparam logic [31:0] UNLOCK_WORD1 = 32'hEBCF_1111;

    localparam logic [1:0] SEL_UNLOCK0 = 2'd0;
    localparam logic [1:0] SEL_UNLOCK1 = 2'd1;
    localparam logic [1:0] SEL_ADDR    = 2'd2;
    localparam logic [1:0] SEL_CTRL    = 2'd3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CE_ON,
        SQ_RST_LOW,
        SQ_RECOVER,
        SQ_SETTLE,
        SQ_RE_OFF
    } seq_state_e;

    typedef struct packed {
        logic             blank;
        logic [CNT_W-1:0] nbytes;
    } read_req_t;

    function automatic int ps_to_cycles(input int dur_ps, input int period_ps);
        int c;
        c = (dur_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fuse_cfg_regs.sv
module fuse_cfg_regs
    import fuse_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int MAX_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          busy,
    input  logic          seq_finish,
    output logic          launch,
    output read_req_t     req,
    output logic [AW-1:0] start_addr,
    output logic          err_key,
    output logic          err_count,
    output logic          err_busy
);

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_BYTES);

    logic [31:0]   unlock0_q, unlock1_q;
    logic [AW-1:0] addr_q;
    logic          start_req, keys_ok, count_ok;

    assign start_req  = wr_en && (wr_sel == SEL_CTRL);
    assign req.nbytes = wr_data[CNT_W-1:0];
    assign req.blank  = wr_data[CNT_W];
    assign keys_ok    = (unlock0_q == UNLOCK_WORD0) && (unlock1_q == UNLOCK_WORD1);
    assign count_ok   = (req.nbytes != '0) && (req.nbytes <= CNT_LIMIT);
    assign launch     = start_req && !busy && count_ok && keys_ok;
    assign start_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock0_q <= '0;
            unlock1_q <= '0;
            addr_q    <= '0;
        end else begin
            if (seq_finish) begin
                unlock0_q <= '0;
                unlock1_q <= '0;
            end else if (wr_en && wr_sel == SEL_UNLOCK0) begin
                unlock0_q <= wr_data;
            end else if (wr_en && wr_sel == SEL_UNLOCK1) begin
                unlock1_q <= wr_data;
            end
            if (wr_en && wr_sel == SEL_ADDR)
                addr_q <= wr_data[AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_key   <= 1'b0;
            err_count <= 1'b0;
            err_busy  <= 1'b0;
        end else if (launch) begin
            err_key   <= 1'b0;
            err_count <= 1'b0;
            err_busy  <= 1'b0;
        end else if (start_req) begin
            if (busy)
                err_busy <= 1'b1;
            else if (!count_ok)
                err_count <= 1'b1;
            else if (!keys_ok)
                err_key <= 1'b1;
        end
    end

    AST_LAUNCH_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        launch |-> (unlock0_q == UNLOCK_WORD0 && unlock1_q == UNLOCK_WORD1)); // R1
    AST_LAUNCH_COUNT: assert property (@(posedge clk) disable iff (rst)
        launch |-> (wr_data[CNT_W-1:0] != '0)); // R2
    AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !launch); // R3
    AST_KEYS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        seq_finish |=> (unlock0_q == '0 && unlock1_q == '0)); // R9

endmodule

// File: rtl/fuse_seq_fsm.sv
module fuse_seq_fsm
    import fuse_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int TW        = 8,
    parameter int RST_CYC   = 3,
    parameter int RCV_CYC   = 125,
    parameter int NORM_CYC  = 9,
    parameter int BLANK_CYC = 188
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  read_req_t     req,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] fuse_dout,
    output logic          fuse_ceb_n,
    output logic          fuse_rstb_n,
    output logic          fuse_rden,
    output logic [AW-1:0] fuse_addr,
    output logic          cap_push,
    output logic [7:0]    cap_byte,
    output logic          seq_finish,
    output logic          busy,
    output logic          done
);

    localparam logic [TW-1:0] RST_LOAD   = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] RCV_LOAD   = TW'(RCV_CYC - 1);
    localparam logic [TW-1:0] NORM_LOAD  = TW'(NORM_CYC - 1);
    localparam logic [TW-1:0] BLANK_LOAD = TW'(BLANK_CYC - 1);
    localparam logic [AW-1:0] BYTE_STEP  = AW'(8);

    seq_state_e       state_q;
    logic [TW-1:0]    timer_q;
    logic [AW-1:0]    addr_q;
    logic [CNT_W-1:0] left_q;
    logic             blank_q;
    logic             timer_zero;
    logic [TW-1:0]    settle_load;

    logic unused_dout_bits;
    assign unused_dout_bits = ^fuse_dout[DW-1:8];

    assign timer_zero  = (timer_q == '0);
    assign settle_load = blank_q ? BLANK_LOAD : NORM_LOAD;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            timer_q <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            blank_q <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= (state_q == SQ_RE_OFF);
            unique case (state_q)
                SQ_IDLE: begin
                    if (launch) begin
                        state_q <= SQ_CE_ON;
                        addr_q  <= start_addr;
                        left_q  <= req.nbytes;
                        blank_q <= req.blank;
                    end
                end
                SQ_CE_ON: begin
                    state_q <= SQ_RST_LOW;
                    timer_q <= RST_LOAD;
                end
                SQ_RST_LOW: begin
                    if (timer_zero) begin
                        state_q <= SQ_RECOVER;
                        timer_q <= RCV_LOAD;
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                SQ_RECOVER: begin
                    if (timer_zero) begin
                        state_q <= SQ_SETTLE;
                        timer_q <= settle_load;
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                SQ_SETTLE: begin
                    if (timer_zero) begin
                        if (left_q == CNT_W'(1)) begin
                            state_q <= SQ_RE_OFF;
                        end else begin
                            addr_q  <= addr_q + BYTE_STEP;
                            left_q  <= left_q - 1'b1;
                            timer_q <= settle_load;
                        end
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                SQ_RE_OFF: state_q <= SQ_IDLE;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    assign fuse_ceb_n  = (state_q == SQ_IDLE);
    assign fuse_rstb_n = (state_q != SQ_RST_LOW);
    assign fuse_rden   = (state_q == SQ_SETTLE);
    assign fuse_addr   = fuse_rden ? addr_q : '0;
    assign cap_push    = fuse_rden && timer_zero;
    assign cap_byte    = fuse_dout[7:0];
    assign seq_finish  = (state_q == SQ_RE_OFF);
    assign busy        = !fuse_ceb_n;

    AST_RST_UNDER_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !fuse_rstb_n |-> !fuse_ceb_n); // R4
    AST_RST_AFTER_CE: assert property (@(posedge clk) disable iff (rst)
        $fell(fuse_rstb_n) |-> $past(!fuse_ceb_n && fuse_rstb_n)); // R4
    AST_CAPTURE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        cap_push |-> (fuse_rden && fuse_rstb_n && !fuse_ceb_n)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cap_push && left_q != CNT_W'(1)) |=> (fuse_addr == $past(fuse_addr) + BYTE_STEP)); // R6
    AST_RDEN_DROPS_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(fuse_ceb_n) |-> $past(!fuse_rden && !fuse_ceb_n)); // R8
    AST_DONE_WITH_STANDBY: assert property (@(posedge clk) disable iff (rst)
        done |-> (fuse_ceb_n && !busy)); // R8

endmodule

// File: rtl/fuse_byte_fifo.sv
module fuse_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop, do_push;

    assign not_empty = (cnt_q != '0);
    assign head      = mem_q[rd_ptr_q];
    assign do_pop    = pop && not_empty;
    assign do_push   = push && ((cnt_q != FULL_CNT) || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_ptr_q] <= push_data;
                wr_ptr_q <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop)
                rd_ptr_q <= (rd_ptr_q == LAST_SLOT) ? '0 : rd_ptr_q + 1'b1;
            if (do_push && !do_pop)
                cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT); // R10
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL_CNT && push && !pop) |=> (cnt_q == FULL_CNT && $stable(wr_ptr_q))); // R10

endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
    import fuse_seq_pkg::*;
#(
    parameter int CLK_PS      = 8000,
    parameter int RST_LOW_PS  = 20000,
    parameter int RECOVER_PS  = 1000000,
    parameter int SETTLE_PS   = 70000,
    parameter int BLANK_PS    = 1500000,
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int FIFO_DEPTH  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          rd_pop,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    output logic          busy,
    output logic          done,
    output logic          err_key,
    output logic          err_count,
    output logic          err_busy,
    output logic          fuse_ceb_n,
    output logic          fuse_rstb_n,
    output logic          fuse_rden,
    output logic [AW-1:0] fuse_addr,
    input  logic [DW-1:0] fuse_dout
);

    localparam int RST_CYC   = ps_to_cycles(RST_LOW_PS, CLK_PS);
    localparam int RCV_CYC   = ps_to_cycles(RECOVER_PS, CLK_PS);
    localparam int NORM_CYC  = ps_to_cycles(SETTLE_PS, CLK_PS);
    localparam int BLANK_CYC = ps_to_cycles(BLANK_PS, CLK_PS);
    localparam int MAX_CYC   = max2(max2(RST_CYC, RCV_CYC), max2(NORM_CYC, BLANK_CYC));
    localparam int TW        = $clog2(MAX_CYC + 1);

    logic          launch;
    read_req_t     req;
    logic [AW-1:0] start_addr;
    logic          seq_finish;
    logic          cap_push;
    logic [7:0]    cap_byte;

    fuse_cfg_regs #(
        .AW        (AW),
        .MAX_BYTES (FIFO_DEPTH)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr),
        .wr_sel     (cfg_sel),
        .wr_data    (cfg_wdata),
        .busy       (busy),
        .seq_finish (seq_finish),
        .launch     (launch),
        .req        (req),
        .start_addr (start_addr),
        .err_key    (err_key),
        .err_count  (err_count),
        .err_busy   (err_busy)
    );

    fuse_seq_fsm #(
        .AW        (AW),
        .DW        (DW),
        .TW        (TW),
        .RST_CYC   (RST_CYC),
        .RCV_CYC   (RCV_CYC),
        .NORM_CYC  (NORM_CYC),
        .BLANK_CYC (BLANK_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .req         (req),
        .start_addr  (start_addr),
        .fuse_dout   (fuse_dout),
        .fuse_ceb_n  (fuse_ceb_n),
        .fuse_rstb_n (fuse_rstb_n),
        .fuse_rden   (fuse_rden),
        .fuse_addr   (fuse_addr),
        .cap_push    (cap_push),
        .cap_byte    (cap_byte),
        .seq_finish  (seq_finish),
        .busy        (busy),
        .done        (done)
    );

    fuse_byte_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (8)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (cap_push),
        .push_data (cap_byte),
        .pop       (rd_pop),
        .head      (rd_data),
        .not_empty (rd_valid)
    );

    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
        fuse_ceb_n |-> (fuse_rstb_n && !fuse_rden)); // R2

endmodule

// File: tb/fuse_read_seq_test.sv
module fuse_read_seq_test;

    localparam int CLK_PS   = 8000;
    localparam int EXP_RST  = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int EXP_RCV  = (1000000 + CLK_PS - 1) / CLK_PS;
    localparam int EXP_NORM = (70000 + CLK_PS - 1) / CLK_PS;
    localparam int EXP_BLNK = (1500000 + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        rd_pop = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid, busy, done, err_key, err_count, err_busy;
    logic        fuse_ceb_n, fuse_rstb_n, fuse_rden;
    logic [15:0] fuse_addr;
    logic [31:0] fuse_dout;

    always #4ns clk = ~clk;

    fuse_read_seq uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
        .err_key(err_key), .err_count(err_count), .err_busy(err_busy),
        .fuse_ceb_n(fuse_ceb_n), .fuse_rstb_n(fuse_rstb_n), .fuse_rden(fuse_rden),
        .fuse_addr(fuse_addr), .fuse_dout(fuse_dout)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        return (a[10:3] * 8'd7) ^ a[15:8] ^ 8'h5B;
    endfunction

    // Fuse macro stub: correct data only after the required settle hold.
    int          need_settle = EXP_NORM;
    int          held = 0;
    logic [15:0] last_addr = '0;
    always @(negedge clk) begin
        if (fuse_rden && fuse_addr == last_addr) held <= held + 1;
        else held <= 1;
        last_addr <= fuse_addr;
    end
    always_comb begin
        if (!fuse_ceb_n && fuse_rden && held >= need_settle)
            fuse_dout = {8'hA7, fuse_addr[7:0], 8'h3E, exp_byte(fuse_addr)};
        else
            fuse_dout = {24'hFFFFFF, ~exp_byte(fuse_addr)};
    end

    // Pin phase monitor.
    int phase = 0;
    int c_ce, c_rst, c_rcv, c_set, c_off;
    int r_ce, r_rst, r_rcv, r_set, r_off;
    bit r_done, r_busy, activity;
    always @(negedge clk) begin
        if (!fuse_ceb_n) activity <= 1'b1;
        if (!fuse_ceb_n) begin
            case (phase)
                0: begin phase <= 1; c_ce <= 1; end
                1: if (!fuse_rstb_n) begin phase <= 2; c_rst <= 1; end else c_ce <= c_ce + 1;
                2: if (fuse_rstb_n) begin phase <= 3; c_rcv <= 1; end else c_rst <= c_rst + 1;
                3: if (fuse_rden) begin phase <= 4; c_set <= 1; end else c_rcv <= c_rcv + 1;
                4: if (!fuse_rden) begin phase <= 5; c_off <= 1; end else c_set <= c_set + 1;
                default: c_off <= c_off + 1;
            endcase
        end else if (phase != 0) begin
            phase <= 0;
            r_ce <= c_ce; r_rst <= c_rst; r_rcv <= c_rcv; r_set <= c_set; r_off <= c_off;
            r_done <= done; r_busy <= busy;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic unlock();
        wr(2'd0, 32'hEBCF_0000);
        wr(2'd1, 32'hEBCF_1111);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string tag);
        check(rd_valid === 1'b1, tag, rd_valid, 1);
        check(rd_data === exp, tag, rd_data, exp);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    // Full read with pin-timing checks; optionally drains and compares the bytes.
    task automatic run_read(input logic [15:0] a0, input int n, input bit blank, input bit drain,
                            input bit poke_busy);
        int settle;
        settle = blank ? EXP_BLNK : EXP_NORM;
        need_settle = settle;
        unlock();
        wr(2'd2, {16'h0, a0});
        wr(2'd3, {27'd0, blank, 4'(n)});
        check(busy === 1'b1, "R8 busy after launch", busy, 1);
        check({err_key, err_count, err_busy} === 3'b000, "R3 errors cleared on launch",
              {err_key, err_count, err_busy}, 0);
        if (poke_busy) begin
            wr(2'd3, {27'd0, blank, 4'(n)});
            check(err_busy === 1'b1, "R3 start while busy flagged", err_busy, 1);
        end
        wait_done();
        check(r_ce == 1, "R4 enable lead cycles", r_ce, 1);
        check(r_rst == EXP_RST, "R4 reset low cycles", r_rst, EXP_RST);
        check(r_rcv == EXP_RCV, "R4 recovery cycles", r_rcv, EXP_RCV);
        check(r_set == settle * n, "R5 read enable cycles", r_set, settle * n);
        check(r_off == 1, "R8 read enable drops before standby", r_off, 1);
        check(r_done === 1'b1 && r_busy === 1'b0, "R8 done and busy at standby",
              {r_done, r_busy}, 2'b10);
        if (drain) begin
            for (int i = 0; i < n; i++)
                pop_expect(exp_byte(a0 + 16'(8 * i)), "R6 R7 captured byte");
            check(rd_valid === 1'b0, "R10 empty after drain", rd_valid, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({fuse_ceb_n, fuse_rstb_n, fuse_rden} === 3'b110, "R8 reset pins idle",
              {fuse_ceb_n, fuse_rstb_n, fuse_rden}, 3'b110);
        check({busy, done, rd_valid, err_key, err_count, err_busy} === 6'b0, "R10 reset state",
              {busy, done, rd_valid, err_key, err_count, err_busy}, 0);

        // R1: no unlock, then one wrong word.
        activity = 1'b0;
        wr(2'd3, 32'd2);
        repeat (5) @(negedge clk);
        check(err_key === 1'b1, "R1 locked start refused", err_key, 1);
        wr(2'd0, 32'hEBCF_0000);
        wr(2'd1, 32'hEBCF_1110);
        wr(2'd3, 32'd2);
        repeat (5) @(negedge clk);
        check(err_key === 1'b1, "R1 wrong word refused", err_key, 1);
        check(activity == 1'b0 && busy === 1'b0, "R1 pins untouched", activity, 0);

        // R2: bad counts with valid keys.
        unlock();
        wr(2'd3, 32'd0);
        repeat (3) @(negedge clk);
        check(err_count === 1'b1, "R2 zero count refused", err_count, 1);
        wr(2'd3, 32'd9);
        repeat (3) @(negedge clk);
        check(err_count === 1'b1 && activity == 1'b0, "R2 count nine refused, pins idle",
              {err_count, activity}, 2'b10);

        // Sweep all counts in normal mode.
        for (int n = 1; n <= 8; n++) begin
            run_read(16'h0100 + 16'(n * 40), n, 1'b0, 1'b1, n == 3);
            // R9: keys cleared, a bare start is refused.
            activity = 1'b0;
            wr(2'd3, 32'd1);
            repeat (3) @(negedge clk);
            check(err_key === 1'b1 && activity == 1'b0, "R9 keys cleared after read",
                  {err_key, activity}, 2'b10);
        end

        // Blank-check mode.
        run_read(16'h0800, 2, 1'b1, 1'b1, 1'b0);
        run_read(16'h1FC0, 8, 1'b1, 1'b1, 1'b0);

        // R10: full FIFO, capture without pop is discarded.
        run_read(16'h0040, 8, 1'b0, 1'b0, 1'b0);
        run_read(16'h0400, 1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++)
            pop_expect(exp_byte(16'h0040 + 16'(8 * i)), "R10 full discard keeps old bytes");
        check(rd_valid === 1'b0, "R10 nothing extra kept", rd_valid, 0);

        // R10: full FIFO, pop in the capture cycle.
        run_read(16'h0040, 8, 1'b0, 1'b0, 1'b0);
        need_settle = EXP_NORM;
        unlock();
        wr(2'd2, 32'h0000_0400);
        wr(2'd3, 32'd1);
        while (!fuse_rden) @(negedge clk);
        repeat (EXP_NORM - 1) @(negedge clk);
        check(rd_data === exp_byte(16'h0040), "R10 head before simultaneous pop", rd_data,
              exp_byte(16'h0040));
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        wait_done();
        for (int i = 1; i < 8; i++)
            pop_expect(exp_byte(16'h0040 + 16'(8 * i)), "R10 older bytes after push-pop");
        pop_expect(exp_byte(16'h0400), "R10 new byte kept on push-pop");
        check(rd_valid === 1'b0, "R10 empty at end", rd_valid, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule